// File: doc/BRIEF.md
# Serial Engine with Master SPI Mode

This block is a serial engine whose datapath can run in several framing modes; only its master SPI mode is built here. A 2-bit mode field in the mode register picks the operating mode. With the field at 11 the engine acts as an SPI master. It produces the serial clock, shifts 8-bit frames out on `mosi`, and samples `miso` into a receive buffer. Software reaches it through a small register port with a byte-wide write strobe and a registered read.

Transmit data passes through a one-byte buffer in front of the shift register. A byte queued while a frame is shifting goes out directly behind it, with no idle clock between the two frames. The serial clock runs at the system clock divided by 2×(divisor+1), where the divisor is 12 bits wide. Two interrupt lines are each gated by their own enable and by a global enable input: one for a finished transmission, one for a free transmit buffer.

Top module: `spim_engine`

Register map (`addr`): 0 DATA (write: transmit buffer, read: receive buffer), 1 STAT (bit 7 rx-done, bit 6 tx-done, bit 5 buffer-free), 2 CTRL (bit 7 tx-done irq enable, bit 6 buffer-free irq enable, bit 5 rx enable, bit 4 tx enable), 3 MODE (bits 7:6 mode, bit 2 LSB-first, bit 1 phase, bit 0 polarity), 4 DIVL (divisor bits 7:0), 5 DIVH (divisor bits 11:8 in bits 3:0).

## Requirements
- R1: Transfers start only when MODE bits 7:6 are 11. With 00, 01 or 10 a queued byte stays in the buffer (STAT bit 5 reads 0) and `sck` does not toggle.
- R2: After reset MODE reads 0x06, STAT reads 0x20, CTRL reads 0x00, and `sck`, `mosi_oe`, `irq_txc` and `irq_dre` are 0.
- R3: With MODE bit 2 = 1 the frame is shifted LSB first; with bit 2 = 0 it is shifted MSB first. Received bits are assembled in the same order.
- R4: Between frames `sck` rests at the MODE bit 0 level. With phase (bit 1) = 0, `miso` is sampled and `mosi` is valid on the leading edge of each clock cycle. With phase = 1, sampling happens on the trailing edge.
- R5: Every half period of `sck` inside a frame lasts exactly divisor+1 system clock cycles. The divisor is {DIVH[3:0], DIVL}.
- R6: A DATA write is accepted only while STAT bit 5 is 1; a write while it is 0 is dropped. A byte accepted during a frame starts exactly divisor+1 cycles after that frame's last edge.
- R7: STAT bit 6 sets when a frame ends and no byte is waiting. Writing STAT with bit 6 = 1, or pulsing `txc_ack`, clears it.
- R8: `irq_txc` is 1 exactly when CTRL bit 7, `gie` and STAT bit 6 were all 1 in the previous cycle. `irq_dre` follows the same rule with CTRL bit 6 and STAT bit 5.
- R9: Clearing CTRL bit 4 does not stop the transfer in progress or the byte already queued. `mosi_oe` stays 1 until the shift register and the buffer are both empty, and then falls.
- R10: A frame that ends while CTRL bit 5 = 1 loads the received byte into the receive buffer and sets STAT bit 7. Reading DATA returns that byte and clears bit 7. A frame that ends with bit 5 = 0 captures nothing.
- R11: A CTRL write with bit 5 = 0 flushes the receiver: STAT bit 7 clears and DATA reads 0x00.
- R12: With CTRL bit 5 = 1 and bit 4 = 0, a queued byte starts no transfer.
- R13: MODE fields written together with the mode bits apply at once: `sck` shows the new idle polarity two cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data on `rdata` the next cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable |
| txc_ack | input | 1 | Interrupt-serviced pulse; clears the tx-done flag |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Transmitter owns the data-out pin |
| irq_txc | output | 1 | Transmission-complete interrupt request |
| irq_dre | output | 1 | Transmit-buffer-free interrupt request |

## Verification
The assertions assume that software does not rewrite MODE or the divisor while a frame is shifting, and that `gie` and `txc_ack` are synchronous to `clk`. The bench changes MODE and the divisor only when the engine is idle, which it confirms first by seeing the tx-done flag. It drives every input on the falling clock edge. The SPI peripheral is a loopback model that returns the inverse of `mosi` on `miso`, so data order, sample edge and receive assembly can all be checked against a single queued byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_STAT = 3'd1,
    A_CTRL = 3'd2,
    A_MODE = 3'd3,
    A_DIVL = 3'd4,
    A_DIVH = 3'd5
  } addr_e;

  typedef enum logic [1:0] {
    M_ASYNC = 2'b00,
    M_SYNC  = 2'b01,
    M_RSVD  = 2'b10,
    M_SPI   = 2'b11
  } mode_e;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_on,
  input  logic          txen,
  input  logic          tick,
  input  logic          lsb_first,
  input  logic          pha,
  input  logic          pol,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic          miso,
  output logic          load,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          busy,
  output logic          sck,
  output logic          mosi
);
  localparam int HCW = $clog2(2 * DW);
  localparam logic [HCW-1:0] LAST = HCW'(2 * DW - 1);

  logic [HCW-1:0] hc_q;
  logic [DW-1:0]  tx_q, rx_q, rx_nxt;
  logic           busy_q, sck_q;
  logic           step, lead, samp, shft;

  assign step = busy_q && tick;
  assign lead = ~hc_q[0];
  assign samp = step && (pha ? ~lead : lead);
  assign shft = step && (pha ? (lead && hc_q != '0) : ~lead);
  assign done = step && (hc_q == LAST);
  assign load = spi_on && buf_full && (busy_q ? done : txen);

  assign rx_nxt  = lsb_first ? {miso, rx_q[DW-1:1]} : {rx_q[DW-2:0], miso};
  assign rx_byte = samp ? rx_nxt : rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      hc_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
    end else begin
      if (step) begin
        hc_q  <= (hc_q == LAST) ? '0 : hc_q + 1'b1;
        sck_q <= ~sck_q;
      end else if (!busy_q) begin
        sck_q <= pol;
      end
      if (shft) tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
      if (samp) rx_q <= rx_nxt;
      if (done) busy_q <= 1'b0;
      if (load) begin
        tx_q   <= buf_data;
        hc_q   <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign mosi = lsb_first ? tx_q[0] : tx_q[DW-1];
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            gie,
  input  logic            txc_ack,
  input  logic            load,
  input  logic            done,
  input  logic [DW-1:0]   rx_byte,
  input  logic            busy,
  output logic            spi_on,
  output logic            lsb_first,
  output logic            pha,
  output logic            pol,
  output logic            txen,
  output logic [DIVW-1:0] div,
  output logic            buf_full,
  output logic [DW-1:0]   buf_data,
  output logic            txc_flag,
  output logic            mosi_oe,
  output logic            irq_txc,
  output logic            irq_dre
);
  localparam int HIW = DIVW - 8;

  logic [1:0]    mode_q;
  logic          lsb_q, pha_q, pol_q;
  logic          txcie_q, dreie_q, rxen_q, txen_q;
  logic [DIVW-1:0] div_q;
  logic          full_q, rxc_q, txc_q, oe_q, itxc_q, idre_q;
  logic [DW-1:0] bufd_q, rxbuf_q, rdata_q;
  addr_e         a;

  assign a = addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_ASYNC;
      lsb_q   <= 1'b1;
      pha_q   <= 1'b1;
      pol_q   <= 1'b0;
      txcie_q <= 1'b0;
      dreie_q <= 1'b0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
      div_q   <= '0;
      full_q  <= 1'b0;
      bufd_q  <= '0;
      rxbuf_q <= '0;
      rxc_q   <= 1'b0;
      txc_q   <= 1'b0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
      itxc_q  <= 1'b0;
      idre_q  <= 1'b0;
    end else begin
      if (rd_en) begin
        case (a)
          A_DATA:  rdata_q <= rxbuf_q;
          A_STAT:  rdata_q <= DW'({rxc_q, txc_q, ~full_q, 5'b0});
          A_CTRL:  rdata_q <= DW'({txcie_q, dreie_q, rxen_q, txen_q, 4'b0});
          A_MODE:  rdata_q <= DW'({mode_q, 3'b0, lsb_q, pha_q, pol_q});
          A_DIVL:  rdata_q <= div_q[7:0];
          A_DIVH:  rdata_q <= DW'(div_q[DIVW-1:8]);
          default: rdata_q <= '0;
        endcase
        if (a == A_DATA) rxc_q <= 1'b0;
      end

      if (load) full_q <= 1'b0;

      if (done && rxen_q) begin
        rxbuf_q <= rx_byte;
        rxc_q   <= 1'b1;
      end

      if ((wr_en && a == A_STAT && wdata[6]) || txc_ack) txc_q <= 1'b0;
      if (done && !load) txc_q <= 1'b1;

      if (wr_en) begin
        case (a)
          A_DATA: if (!full_q) begin
            bufd_q <= wdata;
            full_q <= 1'b1;
          end
          A_CTRL: begin
            {txcie_q, dreie_q, rxen_q, txen_q} <= wdata[7:4];
            if (!wdata[5]) begin
              rxbuf_q <= '0;
              rxc_q   <= 1'b0;
            end
          end
          A_MODE: begin
            mode_q <= wdata[7:6];
            lsb_q  <= wdata[2];
            pha_q  <= wdata[1];
            pol_q  <= wdata[0];
          end
          A_DIVL:  div_q[7:0] <= wdata;
          A_DIVH:  div_q[DIVW-1:8] <= wdata[HIW-1:0];
          default: ;
        endcase
      end

      oe_q   <= txen_q || busy || full_q;
      itxc_q <= txcie_q && gie && txc_q;
      idre_q <= dreie_q && gie && !full_q;
    end
  end

  assign spi_on    = (mode_q == M_SPI);
  assign lsb_first = lsb_q;
  assign pha       = pha_q;
  assign pol       = pol_q;
  assign txen      = txen_q;
  assign div       = div_q;
  assign buf_full  = full_q;
  assign buf_data  = bufd_q;
  assign txc_flag  = txc_q;
  assign mosi_oe   = oe_q;
  assign irq_txc   = itxc_q;
  assign irq_dre   = idre_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DW   = 8,
  parameter int DIVW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          gie,
  input  logic          txc_ack,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          mosi_oe,
  output logic          irq_txc,
  output logic          irq_dre
);
  logic            spi_on, lsb_first, pha, pol, txen;
  logic            buf_full, txc_flag, load, done, busy, tick;
  logic [DIVW-1:0] div;
  logic [DW-1:0]   buf_data, rx_byte;

  spim_regs #(.DW(DW), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gie(gie), .txc_ack(txc_ack),
    .load(load), .done(done), .rx_byte(rx_byte), .busy(busy),
    .spi_on(spi_on), .lsb_first(lsb_first), .pha(pha), .pol(pol),
    .txen(txen), .div(div), .buf_full(buf_full), .buf_data(buf_data),
    .txc_flag(txc_flag), .mosi_oe(mosi_oe), .irq_txc(irq_txc),
    .irq_dre(irq_dre)
  );

  spim_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
  );

  spim_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .spi_on(spi_on), .txen(txen), .tick(tick),
    .lsb_first(lsb_first), .pha(pha), .pol(pol), .buf_full(buf_full),
    .buf_data(buf_data), .miso(miso), .load(load), .done(done),
    .rx_byte(rx_byte), .busy(busy), .sck(sck), .mosi(mosi)
  );
endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic tick,
  input logic sck,
  input logic pol,
  input logic txen,
  input logic spi_on,
  input logic buf_full,
  input logic mosi_oe,
  input logic irq_txc,
  input logic irq_dre,
  input logic gie,
  input logic txc_flag
);
  assert_irq_txc_R8: assert property (@(posedge clk) disable iff (rst)
    irq_txc |-> $past(gie && txc_flag));

  assert_irq_dre_R8: assert property (@(posedge clk) disable iff (rst)
    irq_dre |-> $past(gie && !buf_full));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sck == $past(pol)));

  assert_clk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> (sck == $past(sck)));

  assert_start_from_buf_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(buf_full));

  assert_start_needs_tx_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(txen && spi_on));

  assert_oe_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> mosi_oe);
endmodule

bind spim_engine spim_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .tick(tick), .sck(sck), .pol(pol),
  .txen(txen), .spi_on(spi_on), .buf_full(buf_full), .mosi_oe(mosi_oe),
  .irq_txc(irq_txc), .irq_dre(irq_dre), .gie(gie), .txc_flag(txc_flag)
);

// File: tb/spim_engine_tb.sv
module spim_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, txc_ack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       miso, sck, mosi, mosi_oe, irq_txc, irq_dre;

  assign miso = ~mosi;

  spim_engine u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gie(gie), .txc_ack(txc_ack),
    .miso(miso), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe),
    .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor state
  logic [7:0] exp_q[$];
  bit   mon_en = 0, mon_lsb = 1, mon_pha = 1;
  int   mon_div = 0, cyc = 0, last_edge = 0, last_gap = 0;
  int   ei = 0, edge_cnt = 0, frames = 0;
  logic sck_prev = 1'b0;
  logic [7:0] obs = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && mon_en && sck !== sck_prev) begin
      edge_cnt++;
      if (ei != 0) chk(cyc - last_edge == mon_div + 1, "R5 half period", cyc - last_edge, mon_div + 1);
      else last_gap = cyc - last_edge;
      if (((ei % 2) == 1) == mon_pha)
        obs = mon_lsb ? {mosi, obs[7:1]} : {obs[6:0], mosi};
      if (ei == 15) begin
        frames++;
        if (exp_q.size() == 0) chk(0, "R6 unexpected frame", obs, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(obs == e, "R3 frame bits", obs, e);
        end
      end
      last_edge = cyc;
      ei = (ei + 1) % 16;
    end
    sck_prev = sck;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic cfg(input logic [1:0] m, input bit lsb, input bit pha, input bit pol, input int dv);
    mon_en = 0;
    reg_wr(3'd4, dv[7:0]);
    reg_wr(3'd5, {4'b0, dv[11:8]});
    reg_wr(3'd3, {m, 3'b0, lsb, pha, pol});
    @(negedge clk);
    chk(sck == pol, "R13 idle level after mode write", sck, pol);
    mon_lsb = lsb; mon_pha = pha; mon_div = dv; ei = 0;
    sck_prev = sck; mon_en = 1;
  endtask

  task automatic wait_txc();
    logic [7:0] v;
    v = '0;
    while (!v[6]) reg_rd(3'd1, v);
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    reg_wr(3'd0, b);
    wait_txc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int e0, f0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sck == 0 && mosi_oe == 0, "R2 pins after reset", {sck, mosi_oe}, 0);
    chk(irq_txc == 0 && irq_dre == 0, "R2 irqs after reset", {irq_txc, irq_dre}, 0);
    reg_rd(3'd3, v); chk(v == 8'h06, "R2 MODE reset", v, 8'h06);
    reg_rd(3'd1, v); chk(v == 8'h20, "R2 STAT reset", v, 8'h20);
    reg_rd(3'd2, v); chk(v == 8'h00, "R2 CTRL reset", v, 8'h00);

    // R1: non-SPI modes hold a queued byte
    reg_wr(3'd2, 8'h30);
    cfg(2'b01, 1, 1, 0, 2);
    reg_wr(3'd0, 8'h3C);
    for (int m = 0; m < 3; m++) begin
      mon_en = 0;
      reg_wr(3'd3, {m[1:0], 6'b000110});
      sck_prev = sck; e0 = edge_cnt; mon_en = 1;
      repeat (60) @(negedge clk);
      chk(edge_cnt == e0, "R1 no clock in non-SPI mode", edge_cnt, e0);
      reg_rd(3'd1, v); chk(v[5] == 0, "R1 byte held", v[5], 0);
    end
    exp_q.push_back(8'h3C);
    cfg(2'b11, 1, 1, 0, 2);
    wait_txc();
    reg_rd(3'd0, v); chk(v == 8'hC3, "R10 rx byte", v, 8'hC3);
    reg_rd(3'd1, v); chk(v[7] == 0, "R10 rx flag cleared by read", v[7], 0);
    chk(v[6] == 1, "R7 tx-done set", v[6], 1);
    reg_wr(3'd1, 8'h40);
    reg_rd(3'd1, v); chk(v[6] == 0, "R7 write-one clear", v[6], 0);

    // R3/R4: all orders and clock modes
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = 8'h1D + 8'(k * 37);
      cfg(2'b11, k[2], k[1], k[0], 2);
      chk(sck == k[0], "R4 idle level", sck, k[0]);
      send(b);
      reg_wr(3'd1, 8'h40);
      reg_rd(3'd0, v); chk(v == ~b, "R4 sampled byte", v, ~b);
      chk(sck == k[0], "R4 back to idle", sck, k[0]);
    end

    // R5/R6: large divisor, back-to-back, dropped write
    cfg(2'b11, 0, 0, 1, 12'h105);
    reg_rd(3'd5, v); chk(v == 8'h01, "R5 DIVH readback", v, 8'h01);
    f0 = frames;
    exp_q.push_back(8'h96); exp_q.push_back(8'h4B);
    reg_wr(3'd0, 8'h96);
    v = '0;
    while (!v[5]) reg_rd(3'd1, v);
    reg_wr(3'd0, 8'h4B);
    reg_wr(3'd0, 8'hFF);
    reg_rd(3'd1, v); chk(v[5] == 0, "R6 buffer full", v[5], 0);
    wait_txc();
    reg_wr(3'd1, 8'h40);
    chk(frames - f0 == 2, "R6 dropped write", frames - f0, 2);
    chk(last_gap == 12'h105 + 1, "R6 no gap between frames", last_gap, 12'h106);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    // R9: deferred transmitter disable
    cfg(2'b11, 1, 0, 0, 1);
    f0 = frames;
    exp_q.push_back(8'hE1); exp_q.push_back(8'h2A);
    reg_wr(3'd0, 8'hE1);
    v = '0;
    while (!v[5]) reg_rd(3'd1, v);
    reg_wr(3'd0, 8'h2A);
    reg_wr(3'd2, 8'h00);
    chk(mosi_oe == 1, "R9 oe held while pending", mosi_oe, 1);
    wait_txc();
    reg_wr(3'd1, 8'h40);
    chk(frames - f0 == 2, "R9 pending bytes sent", frames - f0, 2);
    chk(mosi_oe == 0, "R9 oe released", mosi_oe, 0);

    // R10: no capture with rx disabled; R11 flush
    reg_wr(3'd2, 8'h10);
    send(8'h77);
    reg_wr(3'd1, 8'h40);
    reg_rd(3'd1, v); chk(v[7] == 0, "R10 no capture when disabled", v[7], 0);
    reg_wr(3'd2, 8'h30);
    send(8'h0F);
    reg_wr(3'd1, 8'h40);
    reg_rd(3'd1, v); chk(v[7] == 1, "R10 capture flag", v[7], 1);
    reg_wr(3'd2, 8'h10);
    reg_rd(3'd1, v); chk(v[7] == 0, "R11 flag flushed", v[7], 0);
    reg_rd(3'd0, v); chk(v == 8'h00, "R11 buffer flushed", v, 0);

    // R12: receiver alone starts nothing
    reg_wr(3'd2, 8'h20);
    e0 = edge_cnt;
    reg_wr(3'd0, 8'h5E);
    repeat (80) @(negedge clk);
    chk(edge_cnt == e0, "R12 no clock with rx only", edge_cnt, e0);
    reg_rd(3'd1, v); chk(v[5] == 0, "R12 byte held", v[5], 0);
    exp_q.push_back(8'h5E);
    reg_wr(3'd2, 8'h30);
    wait_txc();
    reg_wr(3'd1, 8'h40);

    // R8/R7: interrupt gating and acknowledge
    reg_wr(3'd2, 8'hD0);
    repeat (2) @(negedge clk);
    chk(irq_dre == 0 && irq_txc == 0, "R8 gie off", {irq_txc, irq_dre}, 0);
    gie = 1;
    repeat (2) @(negedge clk);
    chk(irq_dre == 1, "R8 dre irq", irq_dre, 1);
    chk(irq_txc == 0, "R8 txc irq idle", irq_txc, 0);
    send(8'hB4);
    @(negedge clk);
    chk(irq_txc == 1, "R8 txc irq", irq_txc, 1);
    gie = 0;
    repeat (2) @(negedge clk);
    chk(irq_txc == 0, "R8 txc masked by gie", irq_txc, 0);
    gie = 1;
    txc_ack = 1; @(negedge clk); txc_ack = 0;
    repeat (2) @(negedge clk);
    chk(irq_txc == 0, "R7 ack clears irq", irq_txc, 0);
    reg_rd(3'd1, v); chk(v[6] == 0, "R7 ack clears flag", v[6], 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all frames seen", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule